// File: doc/BRIEF.md
# Three-Way Data Bus Exchanger

The block connects three equal data ports, A, B and C, so that each one can re-broadcast what either of the other two carries. Every port feeds its own storage element. The element works in one of three ways. With the port's pass input high it passes the port input straight through. When that input falls, it holds the last value it took in. With the pass input low, it can also take in a new word on a rising edge of the port's own strobe, but only while that port's active-low capture-enable is asserted.

Each port's output takes one of the two neighbouring storage elements, chosen by the port's select input, in a fixed rotation. An active-low enable per port turns the port's driver off. The bidirectional pins are modelled as a separate input word, an output word and a drive-enable flag, which the pad ring joins into a tri-state pad. The port strobes are sampled by the block's system clock, which must run faster than the strobes. A strobe edge is therefore acted on at the first system clock edge that sees the strobe high after it was low.

Top module: `tri_bus_exchanger`

## Requirements
- R1: After synchronous reset all three storage elements hold zero, so every enabled output reads 0x0000 with its drive flag high.
- R2: While a port's pass input is high, its storage element output follows that port's input word in the same cycle, with no system clock edge needed.
- R3: When the pass input falls, the element keeps the word it took in at the last system clock edge where the pass input was high.
- R4: With the pass input low and the active-low capture-enable at 0, a low-to-high strobe transition is acted on at the next system clock edge. The element then holds the input word present at that edge.
- R5: With the pass input low, a strobe that stays steady (either high or low) leaves the stored word unchanged, even while the input word changes.
- R6: With the pass input low and the capture-enable at 1 (disabled), a strobe rising edge leaves the stored word unchanged.
- R7: Port A outputs the C element when its select is 1 and the B element when its select is 0.
- R8: Port B outputs the A element when its select is 1 and the C element when its select is 0.
- R9: Port C outputs the B element when its select is 1 and the A element when its select is 0.
- R10: A port whose active-low output enable is 1 has its drive flag at 0 and its output word at 0x0000, whatever its select is. A port whose enable is 0 has its drive flag at 1.
- R11: A storage element takes in only its own port's input word and never the word that port is driving out.
- R12: Raising the pass input again after a capture at once replaces the stored word with the live input at the element output.
- R13: A word stored in C can be sent out on B. When that B output is fed into a transparent A, the word appears on C in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples strobes and updates storage |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Word arriving on port A |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_sel | input | 1 | Port A source select (1: C element, 0: B element) |
| a_le | input | 1 | Port A pass input (1: transparent) |
| a_strb | input | 1 | Port A capture strobe, rising edge |
| a_cke_n | input | 1 | Port A capture enable, active low |
| a_out | output | 16 | Word driven onto port A |
| a_drv | output | 1 | Port A pad drive enable |
| b_in | input | 16 | Word arriving on port B |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_sel | input | 1 | Port B source select (1: A element, 0: C element) |
| b_le | input | 1 | Port B pass input (1: transparent) |
| b_strb | input | 1 | Port B capture strobe, rising edge |
| b_cke_n | input | 1 | Port B capture enable, active low |
| b_out | output | 16 | Word driven onto port B |
| b_drv | output | 1 | Port B pad drive enable |
| c_in | input | 16 | Word arriving on port C |
| c_oe_n | input | 1 | Port C output enable, active low |
| c_sel | input | 1 | Port C source select (1: B element, 0: A element) |
| c_le | input | 1 | Port C pass input (1: transparent) |
| c_strb | input | 1 | Port C capture strobe, rising edge |
| c_cke_n | input | 1 | Port C capture enable, active low |
| c_out | output | 16 | Word driven onto port C |
| c_drv | output | 1 | Port C pad drive enable |

## Verification
The bench builds the block with its default 16-bit data width, so every check uses full-width words with distinct byte patterns. These patterns show a wrong source or a dropped bit on any port. The port count is fixed at three by the rotation, and all three rotation paths are reached with every select value and every output-enable mask. A bench-side wire can route B's output back into A's input. This setup reaches the chained store, forward and observe case without any change to the design.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

    localparam int NPORT = 3;

    // Per-port control bundle as seen by the storage and steering logic
    typedef struct packed {
        logic oe_n;   // active-low drive enable
        logic sel;    // source select
        logic le;     // pass-through when high
        logic strb;   // capture strobe
        logic cke_n;  // active-low capture enable
    } port_ctl_t;

    // Fixed rotation: select high picks the port two steps ahead, low one step
    function automatic int src_of(input int self_idx, input bit sel_hi);
        return sel_hi ? (self_idx + 2) % NPORT : (self_idx + 1) % NPORT;
    endfunction

endpackage

// File: rtl/xchg_store.sv
module xchg_store
    import xchg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  port_ctl_t     ctl,
    output logic [DW-1:0] view
);

    logic [DW-1:0] stored;
    logic          strb_q;
    logic          strb_rise;

    assign strb_rise = ctl.strb & ~strb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored <= '0;
            strb_q <= 1'b0;
        end else begin
            strb_q <= ctl.strb;
            if (ctl.le) begin
                stored <= din;
            end else if (strb_rise && !ctl.cke_n) begin
                stored <= din;
            end
        end
    end

    assign view = ctl.le ? din : stored;

    // R4: an enabled strobe rise loads the word present at that edge
    assert_edge_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.le && !ctl.cke_n && ctl.strb && !strb_q) |=> (stored == $past(din)));

    // R5 / R6: no enabled rise and latch closed -> the stored word stays put
    assert_hold_closed_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctl.le && (ctl.cke_n || !ctl.strb || strb_q)) |=> $stable(stored));

    // R3: on the falling pass input the element shows the last word seen while open
    assert_latch_close_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.le) |-> (view == $past(din)));

endmodule

// File: rtl/xchg_steer.sv
module xchg_steer
    import xchg_pkg::*;
#(
    parameter int DW   = 16,
    parameter int SELF = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NPORT-1:0][DW-1:0]   views,
    input  port_ctl_t                  ctl,
    output logic [DW-1:0]              dout,
    output logic                       drv
);

    localparam int SRC_HI = src_of(SELF, 1'b1);
    localparam int SRC_LO = src_of(SELF, 1'b0);

    logic [DW-1:0] picked;

    assign picked = ctl.sel ? views[SRC_HI] : views[SRC_LO];
    assign drv    = ~ctl.oe_n;
    assign dout   = ctl.oe_n ? '0 : picked;

    // R10: a disabled port neither drives nor leaks data
    assert_idle_port_R10: assert property (@(posedge clk) disable iff (rst)
        ctl.oe_n |-> (!drv && (dout == '0)));

endmodule

// File: rtl/tri_bus_exchanger.sv
module tri_bus_exchanger
    import xchg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] a_in,
    input  logic          a_oe_n,
    input  logic          a_sel,
    input  logic          a_le,
    input  logic          a_strb,
    input  logic          a_cke_n,
    output logic [DW-1:0] a_out,
    output logic          a_drv,
    input  logic [DW-1:0] b_in,
    input  logic          b_oe_n,
    input  logic          b_sel,
    input  logic          b_le,
    input  logic          b_strb,
    input  logic          b_cke_n,
    output logic [DW-1:0] b_out,
    output logic          b_drv,
    input  logic [DW-1:0] c_in,
    input  logic          c_oe_n,
    input  logic          c_sel,
    input  logic          c_le,
    input  logic          c_strb,
    input  logic          c_cke_n,
    output logic [DW-1:0] c_out,
    output logic          c_drv
);

    logic [NPORT-1:0][DW-1:0] din_w;
    logic [NPORT-1:0][DW-1:0] view_w;
    logic [NPORT-1:0][DW-1:0] dout_w;
    logic [NPORT-1:0]         drv_w;
    port_ctl_t                ctl_w [NPORT];

    assign din_w[0] = a_in;
    assign din_w[1] = b_in;
    assign din_w[2] = c_in;

    assign ctl_w[0] = '{oe_n: a_oe_n, sel: a_sel, le: a_le, strb: a_strb, cke_n: a_cke_n};
    assign ctl_w[1] = '{oe_n: b_oe_n, sel: b_sel, le: b_le, strb: b_strb, cke_n: b_cke_n};
    assign ctl_w[2] = '{oe_n: c_oe_n, sel: c_sel, le: c_le, strb: c_strb, cke_n: c_cke_n};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        xchg_store #(.DW(DW)) u_store (
            .clk  (clk),
            .rst  (rst),
            .din  (din_w[p]),
            .ctl  (ctl_w[p]),
            .view (view_w[p])
        );
        xchg_steer #(.DW(DW), .SELF(p)) u_steer (
            .clk   (clk),
            .rst   (rst),
            .views (view_w),
            .ctl   (ctl_w[p]),
            .dout  (dout_w[p]),
            .drv   (drv_w[p])
        );
    end

    assign a_out = dout_w[0];
    assign b_out = dout_w[1];
    assign c_out = dout_w[2];
    assign a_drv = drv_w[0];
    assign b_drv = drv_w[1];
    assign c_drv = drv_w[2];

    // R2: a transparent B element reaches port A in the same cycle
    assert_pass_through_R2: assert property (@(posedge clk) disable iff (rst)
        (b_le && !a_oe_n && !a_sel) |-> (a_out == b_in));

    // R7: port A with select high shows a transparent C input
    assert_a_from_c_R7: assert property (@(posedge clk) disable iff (rst)
        (c_le && !a_oe_n && a_sel) |-> (a_out == c_in));

    // R8: port B with select high shows a transparent A input
    assert_b_from_a_R8: assert property (@(posedge clk) disable iff (rst)
        (a_le && !b_oe_n && b_sel) |-> (b_out == a_in));

    // R9: port C with select high shows a transparent B input
    assert_c_from_b_R9: assert property (@(posedge clk) disable iff (rst)
        (b_le && !c_oe_n && c_sel) |-> (c_out == b_in));

endmodule

// File: tb/tri_bus_exchanger_tb.sv
module tri_bus_exchanger_tb;

    typedef struct {
        string       tag;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] c;
        logic [2:0]  drv;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] a_drive = '0, b_in = '0, c_in = '0;
    logic [15:0] a_in;
    logic a_oe_n = 0, a_sel = 0, a_le = 0, a_strb = 0, a_cke_n = 1;
    logic b_oe_n = 0, b_sel = 0, b_le = 0, b_strb = 0, b_cke_n = 1;
    logic c_oe_n = 0, c_sel = 0, c_le = 0, c_strb = 0, c_cke_n = 1;
    logic chain = 1'b0;
    logic [15:0] a_out, b_out, c_out;
    logic a_drv, b_drv, c_drv;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    // External wiring used only by the chained case: B's output feeds A's input
    assign a_in = chain ? b_out : a_drive;

    tri_bus_exchanger #(.DW(16)) u_dut (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_oe_n(a_oe_n), .a_sel(a_sel), .a_le(a_le),
        .a_strb(a_strb), .a_cke_n(a_cke_n), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_oe_n(b_oe_n), .b_sel(b_sel), .b_le(b_le),
        .b_strb(b_strb), .b_cke_n(b_cke_n), .b_out(b_out), .b_drv(b_drv),
        .c_in(c_in), .c_oe_n(c_oe_n), .c_sel(c_sel), .c_le(c_le),
        .c_strb(c_strb), .c_cke_n(c_cke_n), .c_out(c_out), .c_drv(c_drv)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Driver side of the scoreboard: queue the expectation, let the monitor compare
    task automatic expect_ports(input string tag, input logic [15:0] ea,
                                input logic [15:0] eb, input logic [15:0] ec,
                                input logic [2:0] edrv);
        exp_t it;
        #1;
        it.tag = tag; it.a = ea; it.b = eb; it.c = ec; it.drv = edrv;
        q.push_back(it);
        #1;
    endtask

    // Monitor: pops expectations and compares with the ports at that moment
    initial begin
        forever begin
            exp_t it;
            wait (q.size() != 0);
            it = q.pop_front();
            total++;
            if (a_out !== it.a || b_out !== it.b || c_out !== it.c ||
                {a_drv, b_drv, c_drv} !== it.drv) begin
                bad++;
                $display("FAIL %s: got a=%h b=%h c=%h drv=%b, expected a=%h b=%h c=%h drv=%b",
                         it.tag, a_out, b_out, c_out, {a_drv, b_drv, c_drv},
                         it.a, it.b, it.c, it.drv);
            end
        end
    end

    // Source per rotation rule (port 0=A,1=B,2=C), written as a table
    function automatic logic [15:0] pick(input int p, input bit s,
                                         input logic [15:0] va, input logic [15:0] vb,
                                         input logic [15:0] vc);
        case (p)
            0: return s ? vc : vb;
            1: return s ? va : vc;
            default: return s ? vb : va;
        endcase
    endfunction

    initial begin
        #(20 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        expect_ports("R1 reset clears storage", 16'h0, 16'h0, 16'h0, 3'b111);

        // R2: transparent B seen on A (sel 0) with no clock edge
        b_in = 16'h1234; b_le = 1;
        expect_ports("R2 pass-through", 16'h1234, 16'h0, 16'h0, 3'b111);
        b_in = 16'hABCD;
        expect_ports("R2 follows input", 16'hABCD, 16'h0, 16'h0, 3'b111);

        // R3: close the latch, change input
        tick();
        b_le = 0; b_in = 16'h5555;
        expect_ports("R3 latch holds", 16'hABCD, 16'h0, 16'h0, 3'b111);

        // R5: strobe steady low with capture enabled
        b_cke_n = 0;
        tick(); tick();
        expect_ports("R5 strobe steady low", 16'hABCD, 16'h0, 16'h0, 3'b111);

        // R4: strobe rise captures
        b_strb = 1;
        tick();
        expect_ports("R4 edge capture", 16'h5555, 16'h0, 16'h0, 3'b111);

        // R5: strobe steady high
        b_in = 16'h6666;
        tick(); tick();
        expect_ports("R5 strobe steady high", 16'h5555, 16'h0, 16'h0, 3'b111);

        // R6: capture disabled blocks a rise
        b_strb = 0;
        tick();
        b_cke_n = 1; b_strb = 1;
        tick(); tick();
        expect_ports("R6 disabled capture", 16'h5555, 16'h0, 16'h0, 3'b111);
        b_strb = 0;

        // R12: back to transparent overrides stored word
        b_le = 1;
        expect_ports("R12 reopen overrides", 16'h6666, 16'h0, 16'h0, 3'b111);
        tick();

        // R7 R8 R9: steering with all elements transparent
        a_drive = 16'hA1A1; b_in = 16'hB2B2; c_in = 16'hC3C3;
        a_le = 1; c_le = 1;
        a_sel = 0; b_sel = 0; c_sel = 0;
        expect_ports("R7 R8 R9 selects low", 16'hB2B2, 16'hC3C3, 16'hA1A1, 3'b111);
        a_sel = 1; b_sel = 1; c_sel = 1;
        expect_ports("R7 R8 R9 selects high", 16'hC3C3, 16'hA1A1, 16'hB2B2, 3'b111);
        a_sel = 1; b_sel = 0; c_sel = 1;
        expect_ports("R7 R8 R9 mixed selects", 16'hC3C3, 16'hC3C3, 16'hB2B2, 3'b111);

        // R10: every enable mask with every select value
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 2; s++) begin
                logic [15:0] ea, eb, ec;
                {a_oe_n, b_oe_n, c_oe_n} = m[2:0];
                a_sel = s[0]; b_sel = s[0]; c_sel = s[0];
                ea = a_oe_n ? 16'h0 : pick(0, s[0], 16'hA1A1, 16'hB2B2, 16'hC3C3);
                eb = b_oe_n ? 16'h0 : pick(1, s[0], 16'hA1A1, 16'hB2B2, 16'hC3C3);
                ec = c_oe_n ? 16'h0 : pick(2, s[0], 16'hA1A1, 16'hB2B2, 16'hC3C3);
                expect_ports("R10 enable mask", ea, eb, ec, ~m[2:0]);
            end
        end
        a_oe_n = 0; b_oe_n = 0; c_oe_n = 0;

        // R11: A drives out while its element takes only a_in
        a_sel = 0; b_sel = 1; c_sel = 1;
        a_drive = 16'h1111;
        expect_ports("R11 own input not own output", 16'hB2B2, 16'h1111, 16'hB2B2, 3'b111);
        tick();
        a_le = 0; a_cke_n = 0; a_strb = 1; a_drive = 16'h2222;
        tick();
        expect_ports("R11 capture from input pin", 16'hB2B2, 16'h2222, 16'hB2B2, 3'b111);

        // R13: store in C, forward via B into transparent A, observe on C
        c_le = 0; c_cke_n = 0; c_strb = 0; c_in = 16'h7E7E;
        tick();
        c_strb = 1;
        tick();
        c_in = 16'h0000;
        b_sel = 0; c_sel = 0; a_le = 1; chain = 1;
        expect_ports("R13 chained forward", 16'hB2B2, 16'h7E7E, 16'h7E7E, 3'b111);

        wait (q.size() == 0);
        #1;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule